// File: doc/BRIEF.md
# Packed 52-bit multiply-accumulate unit

This block is a pipelined vector datapath that works on vectors of 64-bit lanes. Each transaction carries an accumulator vector and two multiplicand vectors. In every active lane the low 52 bits of the two multiplicand lanes are multiplied as unsigned numbers into an exact 104-bit product. One 52-bit half of that product is chosen by a mode bit, zero-extended to 64 bits and added to the accumulator lane. The sum wraps modulo 2^64.

The number of active lanes (`LANES`, 2 or 4) and the physical vector width (`MAX_LANES` lanes) are parameters. Result lanes above the active count are driven to zero. A valid/ready handshake sits at both ends of a three-stage pipeline. The stages are an operand register, a product register and a sum register, and they advance together. The block accepts one transaction per cycle unless the output is stalled.

Top module: `madd52_vec_unit`

## Requirements
- R1: Lane j of every vector occupies bits 64j+63:64j. In the multiplicand lanes only bits 51:0 take part, and bits 63:52 have no effect on the result.
- R2: The two 52-bit multiplicand fields are multiplied as unsigned values into an exact 104-bit product. With both fields all ones, the high half is 2^52-2 and the low half is 1.
- R3: With `mode_hi` = 1, product bits 103:52, zero-extended to 64 bits, are added to the accumulator lane.
- R4: With `mode_hi` = 0, product bits 51:0, zero-extended to 64 bits, are added to the accumulator lane.
- R5: The addition is unsigned, and any carry out of bit 63 is dropped, so the lane result wraps modulo 2^64.
- R6: Lanes are computed independently. Result lanes at index `LANES` and above are always zero, and the accumulator and multiplicand lanes at those indices are ignored.
- R7: `mode_hi` is captured together with the operands, so each transaction uses its own mode even when modes alternate back to back.
- R8: Suppose a transaction is captured at a rising edge (`in_valid` and `in_ready` both high) and `in_ready` stays high. Its result is presented with `out_valid` high after the second following rising edge, and no sooner. At most three transactions are in flight.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_valid` and `res_vec` hold their values into the next cycle.
- R10: A synchronous active-high `rst` empties the pipeline. After reset `out_valid` is 0 and `in_ready` is 1, and no result from before the reset is ever presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input transaction offered |
| in_ready | output | 1 | Pipeline can take a transaction this cycle |
| mode_hi | input | 1 | 1: add product bits 103:52; 0: add product bits 51:0 |
| acc_vec | input | 64*MAX_LANES | Accumulator lanes |
| mul_b_vec | input | 64*MAX_LANES | First multiplicand lanes (bits 51:0 of each used) |
| mul_c_vec | input | 64*MAX_LANES | Second multiplicand lanes (bits 51:0 of each used) |
| out_valid | output | 1 | Result vector valid |
| out_ready | input | 1 | Downstream takes the result this cycle |
| res_vec | output | 64*MAX_LANES | Result lanes; lanes at or above LANES are zero |

## Verification
The bench drives multiplicand lanes whose bits 63:52 are all ones. A design that let those bits into the multiplier would return sums far off the expected values. All-ones 52-bit fields in both modes catch a product truncated below 104 bits or a half taken from the wrong offset, since the two halves differ sharply (2^52-2 against 1). Accumulators just under 2^64 check that the carry is dropped and not pushed into the next lane. Back-to-back transactions with alternating modes, random output stalls and a reset with work in flight show a mode bit that is not carried down the pipe, data that moves during a stall, or a stale result that survives a reset.

// File: rtl/madd52_pkg.sv
package madd52_pkg;
   localparam int unsigned LANE_W     = 64;
   localparam int unsigned MUL_W      = 52;
   localparam int unsigned PROD_W     = 2 * MUL_W;
   localparam int unsigned PAD_W      = LANE_W - MUL_W;
   localparam int unsigned PIPE_DEPTH = 3;

   typedef logic [LANE_W-1:0] lane_t;
   typedef logic [MUL_W-1:0]  mul_t;
   typedef logic [PROD_W-1:0] prod_t;

   typedef enum logic {
      HALF_LO = 1'b0,
      HALF_HI = 1'b1
   } half_sel_e;

   // zero-extended 52-bit slice of the product picked by the mode
   function automatic lane_t widen_half(input prod_t p, input half_sel_e s);
      mul_t part;
      part = (s == HALF_HI) ? p[PROD_W-1:MUL_W] : p[MUL_W-1:0];
      return {{PAD_W{1'b0}}, part};
   endfunction
endpackage

// File: rtl/madd52_pipe_ctrl.sv
module madd52_pipe_ctrl
   import madd52_pkg::*;
#(
   parameter int unsigned DEPTH = PIPE_DEPTH
) (
   input  logic      clk,
   input  logic      rst,
   input  logic      in_valid,
   input  logic      mode_hi,
   input  logic      out_ready,
   output logic      adv,
   output logic      in_ready,
   output logic      out_valid,
   output half_sel_e add_sel
);
   localparam int unsigned MD_N = DEPTH - 1;

   logic [DEPTH-1:0] vld_q;
   half_sel_e        md_q [MD_N];

   if (DEPTH < 3) begin : g_bad_depth
      $error("madd52_pipe_ctrl: DEPTH must be at least 3");
   end

   // one shared enable: every stage moves unless the last one is blocked
   assign adv       = ~(vld_q[DEPTH-1] & ~out_ready);
   assign in_ready  = adv;
   assign out_valid = vld_q[DEPTH-1];
   assign add_sel   = md_q[MD_N-1];

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q <= '0;
      end else if (adv) begin
         vld_q[0] <= in_valid;
         for (int i = 1; i < int'(DEPTH); i++) begin
            vld_q[i] <= vld_q[i-1];
         end
      end
   end

   // mode travels with its operands; no reset needed on data
   always_ff @(posedge clk) begin
      if (adv) begin
         md_q[0] <= half_sel_e'(mode_hi);
         for (int i = 1; i < int'(MD_N); i++) begin
            md_q[i] <= md_q[i-1];
         end
      end
   end
endmodule

// File: rtl/madd52_half_add.sv
module madd52_half_add
   import madd52_pkg::*;
(
   input  lane_t     acc,
   input  prod_t     prod,
   input  half_sel_e sel,
   output lane_t     sum
);
   lane_t addend;

   always_comb begin
      addend = widen_half(prod, sel);
      sum    = acc + addend; // carry out of bit 63 is dropped
   end
endmodule

// File: rtl/madd52_lane.sv
module madd52_lane
   import madd52_pkg::*;
(
   input  logic      clk,
   input  logic      adv,
   input  lane_t     acc_in,
   input  lane_t     mb_in,
   input  lane_t     mc_in,
   input  half_sel_e add_sel,
   output lane_t     res_out
);
   lane_t acc_s1;
   mul_t  b_s1;
   mul_t  c_s1;
   lane_t acc_s2;
   prod_t prod_s2;
   lane_t sum_d;
   lane_t res_s3;
   logic  unused_mul_top;

   assign unused_mul_top = ^{mb_in[LANE_W-1:MUL_W], mc_in[LANE_W-1:MUL_W]};

   // stage 1: operand capture, multiplicands trimmed to 52 bits
   always_ff @(posedge clk) begin
      if (adv) begin
         acc_s1 <= acc_in;
         b_s1   <= mb_in[MUL_W-1:0];
         c_s1   <= mc_in[MUL_W-1:0];
      end
   end

   // stage 2: full-width unsigned product
   always_ff @(posedge clk) begin
      if (adv) begin
         acc_s2  <= acc_s1;
         prod_s2 <= prod_t'(b_s1) * prod_t'(c_s1);
      end
   end

   madd52_half_add u_add (
      .acc  (acc_s2),
      .prod (prod_s2),
      .sel  (add_sel),
      .sum  (sum_d)
   );

   // stage 3: sum register drives the lane output
   always_ff @(posedge clk) begin
      if (adv) begin
         res_s3 <= sum_d;
      end
   end

   assign res_out = res_s3;
endmodule

// File: rtl/madd52_vec_unit.sv
module madd52_vec_unit
   import madd52_pkg::*;
#(
   parameter int unsigned LANES     = 2,
   parameter int unsigned MAX_LANES = 4
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          in_valid,
   output logic                          in_ready,
   input  logic                          mode_hi,
   input  logic [MAX_LANES*LANE_W-1:0]   acc_vec,
   input  logic [MAX_LANES*LANE_W-1:0]   mul_b_vec,
   input  logic [MAX_LANES*LANE_W-1:0]   mul_c_vec,
   output logic                          out_valid,
   input  logic                          out_ready,
   output logic [MAX_LANES*LANE_W-1:0]   res_vec
);
   localparam int unsigned VEC_W = MAX_LANES * LANE_W;
   localparam int unsigned ACT_W = LANES * LANE_W;

   logic      adv;
   half_sel_e add_sel;

   if (!(LANES == 2 || LANES == 4)) begin : g_bad_lanes
      $error("madd52_vec_unit: LANES must be 2 or 4");
   end
   if (MAX_LANES < LANES) begin : g_bad_max
      $error("madd52_vec_unit: MAX_LANES must not be below LANES");
   end

   madd52_pipe_ctrl #(
      .DEPTH (PIPE_DEPTH)
   ) u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .mode_hi   (mode_hi),
      .out_ready (out_ready),
      .adv       (adv),
      .in_ready  (in_ready),
      .out_valid (out_valid),
      .add_sel   (add_sel)
   );

   for (genvar j = 0; j < int'(LANES); j++) begin : g_lane
      madd52_lane u_lane (
         .clk     (clk),
         .adv     (adv),
         .acc_in  (acc_vec  [j*LANE_W +: LANE_W]),
         .mb_in   (mul_b_vec[j*LANE_W +: LANE_W]),
         .mc_in   (mul_c_vec[j*LANE_W +: LANE_W]),
         .add_sel (add_sel),
         .res_out (res_vec  [j*LANE_W +: LANE_W])
      );
   end

   if (MAX_LANES > LANES) begin : g_zero_fill
      logic unused_upper_lanes;
      assign unused_upper_lanes = ^{acc_vec[VEC_W-1:ACT_W],
                                    mul_b_vec[VEC_W-1:ACT_W],
                                    mul_c_vec[VEC_W-1:ACT_W]};
      assign res_vec[VEC_W-1:ACT_W] = '0;
   end
endmodule

// File: rtl/madd52_vec_unit_chk.sv
module madd52_vec_unit_chk #(
   parameter int unsigned VEC_W = 256
) (
   input logic             clk,
   input logic             rst,
   input logic             in_valid,
   input logic             in_ready,
   input logic             out_valid,
   input logic             out_ready,
   input logic [VEC_W-1:0] res_vec
);
   logic [3:0] occ_q;
   logic       take_in;
   logic       give_out;

   assign take_in  = in_valid & in_ready;
   assign give_out = out_valid & out_ready;

   always_ff @(posedge clk) begin
      if (rst) occ_q <= '0;
      else     occ_q <= occ_q + {3'd0, take_in} - {3'd0, give_out};
   end

   assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
      take_in ##1 in_ready ##1 in_ready |=> out_valid);

   assert_occupancy_R8: assert property (@(posedge clk) disable iff (rst)
      occ_q <= 4'd3);

   assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(res_vec)));

   assert_backpressure_R9: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |-> !in_ready);

   assert_reset_empty_R10: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (!out_valid && in_ready));

   assert_no_phantom_R10: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (occ_q != 4'd0));
endmodule

bind madd52_vec_unit madd52_vec_unit_chk #(
   .VEC_W (VEC_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .res_vec   (res_vec)
);

// File: tb/madd52_vec_unit_bench.sv
`timescale 1ns/1ps
module madd52_vec_unit_bench;
   localparam int LANES     = 2;
   localparam int MAX_LANES = 4;
   localparam int VEC_W     = MAX_LANES * 64;
   localparam int SBD       = 1024;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             in_valid = 1'b0;
   logic             in_ready;
   logic             mode_hi = 1'b0;
   logic [VEC_W-1:0] acc_vec = '0;
   logic [VEC_W-1:0] mul_b_vec = '0;
   logic [VEC_W-1:0] mul_c_vec = '0;
   logic             out_valid;
   logic             out_ready = 1'b1;
   logic [VEC_W-1:0] res_vec;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;
   bit rand_rdy = 0;
   string cur_tag = "R3";

   logic [VEC_W-1:0] exp_q [SBD];
   string            tag_q [SBD];
   int wr_i = 0;
   int rd_i = 0;
   bit               prev_stall = 0;
   logic [VEC_W-1:0] prev_res;

   always #2.5 clk = ~clk;

   madd52_vec_unit #(.LANES(LANES), .MAX_LANES(MAX_LANES)) u_madd52_vec_unit (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .mode_hi(mode_hi), .acc_vec(acc_vec), .mul_b_vec(mul_b_vec),
      .mul_c_vec(mul_c_vec), .out_valid(out_valid), .out_ready(out_ready),
      .res_vec(res_vec));

   function automatic logic [63:0] ref_lane(logic [63:0] a, logic [63:0] b,
                                            logic [63:0] c, logic hi);
      logic [127:0] p;
      logic [51:0]  h;
      p = {76'd0, b[51:0]} * {76'd0, c[51:0]};
      h = hi ? p[103:52] : p[51:0];
      return a + {12'd0, h};
   endfunction

   function automatic logic [VEC_W-1:0] ref_vec(logic [VEC_W-1:0] a,
      logic [VEC_W-1:0] b, logic [VEC_W-1:0] c, logic hi);
      logic [VEC_W-1:0] r;
      r = '0;
      for (int j = 0; j < LANES; j++)
         r[j*64 +: 64] = ref_lane(a[j*64 +: 64], b[j*64 +: 64], c[j*64 +: 64], hi);
      return r;
   endfunction

   task automatic check(input bit ok, input string tag, input logic [VEC_W-1:0] act,
                        input logic [VEC_W-1:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   // scoreboard and stall monitor, sampled at the falling edge
   always @(negedge clk) begin
      if (rst) begin
         rd_i = wr_i;
         prev_stall = 0;
      end else begin
         if (prev_stall)
            check(out_valid && res_vec == prev_res, "R9 hold during stall", res_vec, prev_res);
         if (out_valid && !out_ready)
            check(!in_ready, "R9 in_ready low while stalled", {255'd0, in_ready}, '0);
         if (in_valid && in_ready) begin
            exp_q[wr_i % SBD] = ref_vec(acc_vec, mul_b_vec, mul_c_vec, mode_hi);
            tag_q[wr_i % SBD] = cur_tag;
            wr_i++;
         end
         if (out_valid && out_ready) begin
            if (rd_i == wr_i) begin
               check(0, "R10 unexpected result", res_vec, '0);
            end else begin
               check(res_vec === exp_q[rd_i % SBD], tag_q[rd_i % SBD], res_vec, exp_q[rd_i % SBD]);
               rd_i++;
            end
         end
         prev_stall = out_valid && !out_ready;
         prev_res   = res_vec;
      end
   end

   always begin
      @(posedge clk);
      #1;
      if (rand_rdy) out_ready = ($urandom_range(0, 3) != 0);
   end

   // call at posedge+1; returns at posedge+1 after the capture edge
   task automatic send(input logic hi, input logic [VEC_W-1:0] a,
                       input logic [VEC_W-1:0] b, input logic [VEC_W-1:0] c,
                       input string tag);
      bit ok;
      cur_tag   = tag;
      in_valid  = 1'b1;
      mode_hi   = hi;
      acc_vec   = a;
      mul_b_vec = b;
      mul_c_vec = c;
      do begin
         @(negedge clk);
         ok = in_ready;
         @(posedge clk);
      end while (!ok);
      #1;
      in_valid = 1'b0;
   endtask

   function automatic logic [VEC_W-1:0] rnd_vec();
      logic [VEC_W-1:0] v;
      for (int j = 0; j < MAX_LANES; j++) v[j*64 +: 64] = {$urandom(), $urandom()};
      return v;
   endfunction

   task automatic drain();
      rand_rdy  = 0;
      out_ready = 1'b1;
      for (int k = 0; k < 50 && rd_i != wr_i; k++) @(posedge clk);
      check(rd_i == wr_i, "R8 drain", VEC_W'(wr_i - rd_i), '0);
      @(posedge clk);
      #1;
   endtask

   initial begin
      #(5.0 * 150000);
      n_bad++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      report();
   end

   initial begin
      logic [VEC_W-1:0] ones52, top_ones, a, b, c;
      void'($urandom(32'd9127));
      ones52   = '0;
      top_ones = '0;
      for (int j = 0; j < MAX_LANES; j++) begin
         ones52[j*64 +: 64]   = {12'd0, {52{1'b1}}};
         top_ones[j*64 +: 64] = {64{1'b1}};
      end

      repeat (3) @(posedge clk);
      #1;
      rst = 1'b0;
      @(negedge clk);
      // R10: empty after reset
      check(!out_valid && in_ready, "R10 reset state", {254'd0, out_valid, in_ready}, 256'd1);
      @(posedge clk);
      #1;

      // R8: exact latency of a single transaction
      send(1'b1, rnd_vec(), rnd_vec(), rnd_vec(), "R8 single");
      @(negedge clk);
      check(!out_valid, "R8 not after capture edge", {255'd0, out_valid}, '0);
      @(negedge clk);
      check(!out_valid, "R8 not after second edge", {255'd0, out_valid}, '0);
      @(negedge clk);
      check(out_valid, "R8 valid after third edge", {255'd0, out_valid}, 256'd1);
      @(posedge clk);
      #1;
      drain();

      // R2 R3 R4: all-ones 52-bit fields, both halves
      send(1'b1, '0, ones52, ones52, "R3 R2 all-ones high half");
      send(1'b0, '0, ones52, ones52, "R4 R2 all-ones low half");
      // R1: bits 63:52 of multiplicands all ones must be ignored
      send(1'b1, rnd_vec(), top_ones, top_ones, "R1 upper bits ignored hi");
      send(1'b0, rnd_vec(), top_ones, rnd_vec() | top_ones, "R1 upper bits ignored lo");
      // R5: accumulator near 2^64 wraps
      a = '0; b = '0; c = '0;
      for (int j = 0; j < LANES; j++) begin
         a[j*64 +: 64] = 64'hFFFF_FFFF_FFFF_FFF0;
         b[j*64 +: 64] = 64'd8;
         c[j*64 +: 64] = 64'd4;
      end
      send(1'b0, a, b, c, "R5 wrap low mode");
      send(1'b1, top_ones, ones52, ones52, "R5 wrap high mode");
      // R6: upper lanes driven with junk, results must be zero
      send(1'b0, top_ones, top_ones, top_ones, "R6 inactive lanes zero");
      // R7: alternating modes back to back
      a = rnd_vec(); b = rnd_vec(); c = rnd_vec();
      for (int k = 0; k < 6; k++) send(k[0], a, b, c, "R7 alternating modes");
      drain();

      // R10: reset with work in flight
      out_ready = 1'b0;
      send(1'b1, rnd_vec(), rnd_vec(), rnd_vec(), "R10 flushed");
      send(1'b0, rnd_vec(), rnd_vec(), rnd_vec(), "R10 flushed");
      rst = 1'b1;
      repeat (2) @(posedge clk);
      #1;
      rst = 1'b0;
      out_ready = 1'b1;
      @(negedge clk);
      check(!out_valid && in_ready, "R10 flush state", {254'd0, out_valid, in_ready}, 256'd1);
      repeat (5) begin
         @(negedge clk);
         check(!out_valid, "R10 no stale result", {255'd0, out_valid}, '0);
      end
      @(posedge clk);
      #1;

      // random traffic with stalls: R3 R4 R5 R7 R9
      rand_rdy = 1;
      for (int k = 0; k < 400; k++) begin
         a = rnd_vec(); b = rnd_vec(); c = rnd_vec();
         if ($urandom_range(0, 7) == 0) a = a | top_ones;
         if ($urandom_range(0, 7) == 0) b = b | ones52;
         if ($urandom_range(0, 3) == 0) begin
            @(posedge clk);
            #1;
         end
         send($urandom_range(0, 1) == 1, a, b, c, "R7 random mixed modes");
      end
      drain();
      report();
   end
endmodule